// File: doc/BRIEF.md
# Bus-Mapped Successive-Approximation Converter Controller

This block is the digital core of an 8-bit successive-approximation converter that a processor sees as a single memory location. There is no command register. The core works out what to do from the timing of two active-low strobes, a chip select and a read strobe. From those strobes it starts a conversion, drives the result onto the data bus, or resets the converter. An active-low busy output tells the processor when a conversion is running. The result bus has a separate enable that stands in for three-state drivers.

During a conversion the block drives a trial code to an external DAC. It reads back one comparator bit for each decision, trying the bits from the most significant down. A gated divider produces the conversion-clock enable. The divider runs only while a conversion is in progress, and it restarts from zero when a conversion starts, so the first decision is aligned to the start. The processor can use the block in three ways, all with the same logic:

- **Write-style:** a select with no read starts a conversion, and a later read fetches the result.
- **Read-only style:** the select is held low. Each read returns the previous result, and releasing the read starts a new conversion.
- **Wait-state style:** select and read are tied together. One access starts the conversion, holds the processor on busy, and returns the data.

Top module: `busmap_sar_adc`

## Requirements
- R1: After the asynchronous reset, busy_no is 1, data_oe_o is 0, data_o is 0, conv_err_o is 0 and dac_code_o is 0.
- R2: When the converter is idle and cs_ni is low (either level of rd_ni), a conversion starts. busy_no goes low on the third rising clock edge after cs_ni falls. It stays low for exactly 8×DIV cycles, which is one decision every DIV cycles.
- R3: The first trial code is 8'h80. cmp_i = 1 means the DAC output is above the input and clears the bit under trial; cmp_i = 0 keeps it. The final code is the largest code that is not above the input.
- R4: While busy_no is low, toggling cs_ni without a rising edge on rd_ni has no effect. data_oe_o stays 0, the conversion length does not change, and the result is correct.
- R5: data_oe_o is 1 only after a completed conversion and only while both strobes are low. data_o carries the result when data_oe_o is 1 and is 0 otherwise.
- R6: Every rising edge of rd_ni resets the converter, whatever the level of cs_ni. Within three edges data_oe_o is 0, busy_no is 1 and dac_code_o is 0. No conversion starts while cs_ni stays high.
- R7: A rising edge of rd_ni while busy_no is low aborts the conversion and sets conv_err_o. The flag stays set until the next conversion starts, and that start clears it.
- R8: With cs_ni held low, the rd_ni release that ends a read resets the converter. A new conversion follows, with busy_no low on the fourth edge after the release.
- R9: With cs_ni and rd_ni tied together, the falling edge starts a conversion. data_oe_o rises with the result in the same cycle that busy_no returns high. The rising edge turns data_oe_o off.
- R10: After a conversion completes, no new conversion starts until rd_ni rises, even if cs_ni stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select strobe, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| cmp_i | input | 1 | Comparator decision, 1 when the DAC output is above the input |
| dac_code_o | output | DW | Trial code sent to the external DAC |
| busy_no | output | 1 | Low while a conversion is in progress |
| data_o | output | DW | Result bus, 0 when not enabled |
| data_oe_o | output | 1 | Result bus drive enable |
| conv_err_o | output | 1 | Sticky flag for a read released during a conversion |

## Verification
Both strobes pass through a two-stage synchronizer, so each result is due a fixed number of edges after the input changes:

- The read enable is due on the second edge.
- A conversion start or a reset is due on the third edge.
- The restart in read-only use is due on the fourth edge.
- busy_no stays low for 8×DIV cycles.

The bench drives inputs and samples outputs on falling clock edges only. It checks the due cycle and also the cycle before it where that matters. It measures the busy window by counting falling edges. The comparator is modelled combinationally from dac_code_o, so the expected result is simply the input code.

// File: rtl/adcb_pkg.sv
package adcb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_DONE} adc_state_e;
endpackage

// File: rtl/adcb_strobe_sync.sv
module adcb_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rd_ni,
  output logic cs_n_o,
  output logic rd_n_o,
  output logic rd_rise_o
);
  logic [1:0] pipe_q [STAGES];
  logic       rd_last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= 2'b11;
        else         pipe_q[g] <= {cs_ni, rd_ni};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= 2'b11;
        else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rd_last_q <= 1'b1;
    else         rd_last_q <= pipe_q[STAGES-1][0];

  assign cs_n_o    = pipe_q[STAGES-1][1];
  assign rd_n_o    = pipe_q[STAGES-1][0];
  assign rd_rise_o = rd_n_o & ~rd_last_q;

  assert_rise_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rise_o |=> !rd_rise_o);
endmodule

// File: rtl/adcb_tick_gen.sv
module adcb_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  // counter held at zero while gated: first decision lands DIV cycles after start
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                   cnt_q <= '0;
    else if (!en_i)                cnt_q <= '0;
    else if (cnt_q == CW'(DIV-1))  cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;

  assign tick_o = en_i && (cnt_q == CW'(DIV-1));

  assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adcb_sar.sv
module adcb_sar #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic          cmp_i,
  output logic [DW-1:0] code_o,
  output logic [DW-1:0] dec_o,
  output logic          last_o
);
  localparam logic [DW-1:0] MSB = {1'b1, {(DW-1){1'b0}}};
  logic [DW-1:0] code_q, mask_q;

  // decision on the bit under trial: drop it if the DAC overshoots
  assign dec_o  = cmp_i ? (code_q & ~mask_q) : code_q;
  assign code_o = code_q;
  assign last_o = mask_q[0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (clr_i) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      code_q <= MSB;
      mask_q <= MSB;
    end else if (tick_i) begin
      code_q <= dec_o | (mask_q >> 1);
      mask_q <= mask_q >> 1;
    end

  assert_one_trial_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> ($countones(mask_q) == 1));
endmodule

// File: rtl/busmap_sar_adc.sv
module busmap_sar_adc
  import adcb_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          cmp_i,
  output logic [DW-1:0] dac_code_o,
  output logic          busy_no,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          conv_err_o
);
  adc_state_e    state_q, state_d;
  logic          cs_n_s, rd_n_s, rd_rise;
  logic          tick, last, start, done;
  logic [DW-1:0] dec, result_q;
  logic          err_q;

  adcb_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .cs_ni, .rd_ni,
    .cs_n_o(cs_n_s), .rd_n_o(rd_n_s), .rd_rise_o(rd_rise)
  );

  adcb_tick_gen #(.DIV(DIV)) i_tick (
    .clk_i, .rst_ni, .en_i(state_q == ST_CONV), .tick_o(tick)
  );

  adcb_sar #(.DW(DW)) i_sar (
    .clk_i, .rst_ni, .start_i(start), .tick_i(tick), .clr_i(rd_rise),
    .cmp_i, .code_o(dac_code_o), .dec_o(dec), .last_o(last)
  );

  assign start = (state_q == ST_IDLE) && !cs_n_s && !rd_rise;
  assign done  = tick && last;

  // read release outranks everything: reset, abort, deselect
  always_comb begin
    state_d = state_q;
    if (rd_rise) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE: if (start) state_d = ST_CONV;
        ST_CONV: if (done)  state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      result_q <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (rd_rise)   result_q <= '0;
      else if (done) result_q <= dec;
      if (start)                              err_q <= 1'b0;
      else if (rd_rise && state_q == ST_CONV) err_q <= 1'b1;
    end

  assign busy_no    = (state_q != ST_CONV);
  assign data_oe_o  = (state_q == ST_DONE) && !cs_n_s && !rd_n_s;
  assign data_o     = data_oe_o ? result_q : '0;
  assign conv_err_o = err_q;

  assert_oe_not_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> busy_no);
  assert_release_drops_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rise |=> !data_oe_o);
  assert_err_from_conv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_err_o) |-> $past(!busy_no));
  assert_done_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !rd_rise) |=> busy_no);
endmodule

// File: tb/test_busmap_sar_adc.sv
`timescale 1ns/1ps
module test_busmap_sar_adc;
  localparam int DW = 8, DIV = 4, CONV_LEN = 8 * DIV;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rd_n = 1'b1;
  logic [DW-1:0] vin = '0, dac, dout;
  logic busy_n, oe, err, cmp;
  int n_chk = 0, n_bad = 0;
  bit fin = 1'b0;

  assign cmp = (dac > vin);
  always #4 clk = ~clk;

  busmap_sar_adc #(.DW(DW), .DIV(DIV)) i_busmap_sar_adc (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .cmp_i(cmp),
    .dac_code_o(dac), .busy_no(busy_n), .data_o(dout), .data_oe_o(oe),
    .conv_err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_conv(output int len);
    len = 0;
    while (busy_n === 1'b0 && len < 1000) begin
      step(1);
      len++;
    end
  endtask

  task automatic t_reset;
    chk("R1 busy", busy_n, 1);
    chk("R1 oe", oe, 0);
    chk("R1 data", dout, 0);
    chk("R1 err", err, 0);
    chk("R1 dac", dac, 0);
    rst_n = 1'b1;
    step(2);
  endtask

  // write-style start, hold select, then read and release
  task automatic t_ram(input logic [7:0] v);
    int len, bad;
    vin = v; cs_n = 0; rd_n = 1;
    step(2); chk("R2 busy before third edge", busy_n, 1);
    step(1); chk("R2 busy low", busy_n, 0);
    chk("R3 first trial", dac, 8'h80);
    wait_conv(len);
    chk("R2 busy length", len, CONV_LEN);
    chk("R5 oe without read", oe, 0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (busy_n !== 1'b1) bad++; end
    chk("R10 no restart while selected", bad, 0);
    rd_n = 0;
    step(2); chk("R5 oe on read", oe, 1);
    chk("R3 result", dout, v);
    rd_n = 1; cs_n = 1;
    step(3);
    chk("R6 oe off", oe, 0);
    chk("R6 dac cleared", dac, 0);
    step(3); chk("R6 idle while deselected", busy_n, 1);
  endtask

  // select toggling during a conversion
  task automatic t_noise(input logic [7:0] v);
    int len, bad;
    vin = v; cs_n = 0; rd_n = 1;
    step(3); chk("R4 busy low", busy_n, 0);
    len = 0; bad = 0;
    while (busy_n === 1'b0 && len < 1000) begin
      cs_n = (len < 12) ? ~((len >> 1) & 1) : 1'b1;
      step(1); len++;
      if (busy_n === 1'b0 && oe !== 1'b0) bad++;
    end
    chk("R4 length unchanged", len, CONV_LEN);
    chk("R4 bus disabled while busy", bad, 0);
    cs_n = 0; rd_n = 0;
    step(2); chk("R4 result intact", dout, v);
    cs_n = 1; rd_n = 1; step(3);
  endtask

  // read released mid-conversion
  task automatic t_abort(input logic [7:0] v);
    int len;
    vin = 8'h33; cs_n = 0; rd_n = 1;
    step(3); cs_n = 1;
    step(8); rd_n = 0;
    step(2); rd_n = 1;
    step(3);
    chk("R7 err set", err, 1);
    chk("R7 aborted", busy_n, 1);
    step(10); chk("R7 err sticky", err, 1);
    vin = v; cs_n = 0;
    step(3);
    chk("R7 restarted", busy_n, 0);
    chk("R7 err cleared by start", err, 0);
    wait_conv(len);
    rd_n = 0; step(2); chk("R7 result after abort", dout, v);
    cs_n = 1; rd_n = 1; step(3);
  endtask

  // select held low, reads only
  task automatic t_rom(input logic [7:0] v1, input logic [7:0] v2);
    int len;
    vin = v1; cs_n = 0; rd_n = 0;
    step(3); chk("R8 dummy read starts", busy_n, 0);
    wait_conv(len);
    chk("R8 dummy data", dout, v1);
    vin = v2; rd_n = 1;
    step(3);
    chk("R8 reset on release", busy_n, 1);
    chk("R8 dac cleared", dac, 0);
    step(1); chk("R8 restart", busy_n, 0);
    wait_conv(len);
    chk("R8 length", len, CONV_LEN);
    rd_n = 0; step(2);
    chk("R8 oe", oe, 1);
    chk("R8 data", dout, v2);
    cs_n = 1; rd_n = 1; step(4);
    chk("R6 release with select high stays idle", busy_n, 1);
  endtask

  // select and read tied
  task automatic t_slow(input logic [7:0] v);
    int len, bad;
    vin = v; cs_n = 0; rd_n = 0;
    step(3); chk("R9 busy low", busy_n, 0);
    len = 0; bad = 0;
    while (busy_n === 1'b0 && len < 1000) begin
      if (oe !== 1'b0) bad++;
      step(1); len++;
    end
    chk("R9 bus off while busy", bad, 0);
    chk("R9 oe with busy high", oe, 1);
    chk("R9 data", dout, v);
    cs_n = 1; rd_n = 1;
    step(2); chk("R9 oe off", oe, 0);
    step(1); chk("R9 dac cleared", dac, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    step(3);
    t_reset();
    t_ram(8'h5A);
    t_ram(8'h00);
    t_ram(8'hFF);
    t_noise(8'hA5);
    t_abort(8'h01);
    t_rom(8'h80, 8'h7F);
    t_slow(8'hC3);
    t_slow(8'h3C);
    fin = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end
endmodule